// File: doc/BRIEF.md
# Mailbox Doorbell Interrupt Logic

This block adds a doorbell interrupt to each side of a two-port shared memory. Two words at the very top of the address space act as mailboxes, one belonging to each port: the left port owns the second-highest word and the right port owns the highest word. A write from one port into the other port's mailbox rings that port's doorbell. The owning port then clears its interrupt by accessing its own mailbox with the output enable active. The read/write line does not matter for this clear.

The block only watches the access signals. The storage array and the collision arbiter sit outside it. The mailbox words stay ordinary memory words, and this logic only adds the interrupt side effects. Each port also supplies a busy qualifier, which comes from an external arbiter. When a port's busy qualifier is low, that port can neither ring nor acknowledge. Both interrupt outputs are active low, always driven, and registered on a single clock.

Top module: `mbox_doorbell`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, both `lt_irq_n` and `rt_irq_n` are high.
- R2: A right-port write (`rt_sel_n`=0, `rt_we_n`=0, `rt_busy_n`=1) to address 0x3FFE drives `lt_irq_n` low one clock later.
- R3: A left-port write (`lt_sel_n`=0, `lt_we_n`=0, `lt_busy_n`=1) to address 0x3FFF drives `rt_irq_n` low one clock later.
- R4: A left-port access to 0x3FFE with `lt_sel_n`=0, `lt_oe_n`=0 and `lt_busy_n`=1 drives `lt_irq_n` high one clock later. The clear happens whatever the value of `lt_we_n`.
- R5: A right-port access to 0x3FFF with `rt_sel_n`=0, `rt_oe_n`=0 and `rt_busy_n`=1 drives `rt_irq_n` high one clock later, whatever the value of `rt_we_n`.
- R6: When the acting port's busy input is low, its ring or acknowledge leaves the target interrupt output unchanged.
- R7: If a ring and an acknowledge hit the same interrupt in the same cycle, the interrupt ends up active (low).
- R8: The following accesses leave both outputs unchanged:
  - a port writing its own mailbox;
  - a write to any non-mailbox address;
  - an access with `*_sel_n` high;
  - an access to the own mailbox with `*_oe_n` high and no write.
- R9: When no qualifying ring or acknowledge occurs, each interrupt output holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lt_sel_n | input | 1 | Left port enable, active low |
| lt_oe_n | input | 1 | Left port output enable, active low |
| lt_we_n | input | 1 | Left port write request, active low |
| lt_addr | input | ADDR_W (14) | Left port address |
| lt_busy_n | input | 1 | Left port busy qualifier, low vetoes left actions |
| rt_sel_n | input | 1 | Right port enable, active low |
| rt_oe_n | input | 1 | Right port output enable, active low |
| rt_we_n | input | 1 | Right port write request, active low |
| rt_addr | input | ADDR_W (14) | Right port address |
| rt_busy_n | input | 1 | Right port busy qualifier, low vetoes right actions |
| lt_irq_n | output | 1 | Left doorbell interrupt, active low |
| rt_irq_n | output | 1 | Right doorbell interrupt, active low |

## Verification
A ring from the far port and an acknowledge from the owning port can land on the same interrupt in the same clock. The bench provokes this directly: in one cycle it drives a right-port write to 0x3FFE together with a left-port output-enabled access to 0x3FFE. It then judges that `lt_irq_n` is low one clock later. A separate acknowledge in a later cycle must still release the interrupt. The bench also sets up the opposite case, where one port rings while the other port, vetoed by busy, tries to acknowledge. Only the ring may take effect.

// File: rtl/mbox_pkg.sv
// Package: shared control type and helpers for the mailbox doorbell logic.
// Assumes all pin-level controls are active low and are converted once here.
package mbox_pkg;

    // Active-high view of one port's access controls.
    typedef struct packed {
        logic sel;
        logic oe;
        logic wr;
        logic go;   // busy qualifier passes
    } port_ctl_t;

    // Converts active-low pins to the active-high control view.
    function automatic port_ctl_t to_ctl(input logic sel_n, input logic oe_n,
                                         input logic we_n, input logic busy_n);
        port_ctl_t c;
        c.sel = ~sel_n;
        c.oe  = ~oe_n;
        c.wr  = ~we_n;
        c.go  = busy_n;
        return c;
    endfunction

endpackage

// File: rtl/mbox_access_decode.sv
// Module: decodes one port's access into a ring of the peer mailbox and an
// acknowledge of the own mailbox. Assumes the controls are already active high.
module mbox_access_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
    parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
    input  port_ctl_t         ctl,
    input  logic [ADDR_W-1:0] addr,
    output logic              ring_peer,
    output logic              ack_own
);

    // Write to the peer mailbox rings the peer, subject to the busy veto.
    always_comb ring_peer = ctl.sel && ctl.wr && ctl.go && (addr == PEER_BOX);

    // Output-enabled access to the own mailbox acknowledges, read/write ignored.
    always_comb ack_own = ctl.sel && ctl.oe && ctl.go && (addr == OWN_BOX);

endmodule

// File: rtl/mbox_irq_flag.sv
// Module: one registered doorbell flag driving an active-low interrupt.
// Assumes set and clear are single-cycle pulses; set wins when both arrive.
module mbox_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq_n
);

    logic pend;

    // Holds the pending doorbell; set takes precedence over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend <= 1'b0;
        else if (set) pend <= 1'b1;
        else if (clr) pend <= 1'b0;
    end

    // Drives the interrupt pin low while a doorbell is pending.
    always_comb irq_n = ~pend;

endmodule

// File: rtl/mbox_doorbell.sv
// Module: top of the cross-port mailbox doorbell logic. Port 0 is left,
// port 1 is right; the left mailbox is the top address minus one, the right
// mailbox is the top address. Assumes one synchronous clock for both ports.
module mbox_doorbell
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lt_sel_n,
    input  logic              lt_oe_n,
    input  logic              lt_we_n,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              lt_busy_n,
    input  logic              rt_sel_n,
    input  logic              rt_oe_n,
    input  logic              rt_we_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_busy_n,
    output logic              lt_irq_n,
    output logic              rt_irq_n
);

    localparam int NPORT = 2;

    port_ctl_t         ctl  [NPORT];
    logic [ADDR_W-1:0] addr [NPORT];
    logic [NPORT-1:0]  ring;
    logic [NPORT-1:0]  ack;
    logic [NPORT-1:0]  irq_n;

    // Gathers both ports' pins into indexed control views.
    always_comb begin
        ctl[0]  = to_ctl(lt_sel_n, lt_oe_n, lt_we_n, lt_busy_n);
        ctl[1]  = to_ctl(rt_sel_n, rt_oe_n, rt_we_n, rt_busy_n);
        addr[0] = lt_addr;
        addr[1] = rt_addr;
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        localparam logic [ADDR_W-1:0] OWN  = {{(ADDR_W-1){1'b1}}, 1'(i)};
        localparam logic [ADDR_W-1:0] PEER = {{(ADDR_W-1){1'b1}}, 1'(1-i)};

        mbox_access_decode #(
            .ADDR_W  (ADDR_W),
            .OWN_BOX (OWN),
            .PEER_BOX(PEER)
        ) u_dec (
            .ctl      (ctl[i]),
            .addr     (addr[i]),
            .ring_peer(ring[i]),
            .ack_own  (ack[i])
        );

        mbox_irq_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (ring[NPORT-1-i]),
            .clr  (ack[i]),
            .irq_n(irq_n[i])
        );
    end

    // Routes the per-port interrupts to the pins.
    always_comb begin
        lt_irq_n = irq_n[0];
        rt_irq_n = irq_n[1];
    end

endmodule

// File: rtl/mbox_doorbell_chk.sv
// Checker: port-level properties of the doorbell logic, bound to the top.
module mbox_doorbell_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lt_sel_n,
    input logic              lt_oe_n,
    input logic              lt_we_n,
    input logic [ADDR_W-1:0] lt_addr,
    input logic              lt_busy_n,
    input logic              rt_sel_n,
    input logic              rt_oe_n,
    input logic              rt_we_n,
    input logic [ADDR_W-1:0] rt_addr,
    input logic              rt_busy_n,
    input logic              lt_irq_n,
    input logic              rt_irq_n
);

    localparam logic [ADDR_W-1:0] LBOX = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] RBOX = {ADDR_W{1'b1}};

    logic lt_set, lt_clr, rt_set, rt_clr;
    assign lt_set = !rt_sel_n && !rt_we_n && rt_busy_n && (rt_addr == LBOX);
    assign lt_clr = !lt_sel_n && !lt_oe_n && lt_busy_n && (lt_addr == LBOX);
    assign rt_set = !lt_sel_n && !lt_we_n && lt_busy_n && (lt_addr == RBOX);
    assign rt_clr = !rt_sel_n && !rt_oe_n && rt_busy_n && (rt_addr == RBOX);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (lt_irq_n && rt_irq_n)); // R1
    AST_LT_RING: assert property (@(posedge clk) disable iff (!rst_n) lt_set |=> !lt_irq_n); // R2
    AST_RT_RING: assert property (@(posedge clk) disable iff (!rst_n) rt_set |=> !rt_irq_n); // R3
    AST_LT_ACK: assert property (@(posedge clk) disable iff (!rst_n) (lt_clr && !lt_set) |=> lt_irq_n); // R4
    AST_RT_ACK: assert property (@(posedge clk) disable iff (!rst_n) (rt_clr && !rt_set) |=> rt_irq_n); // R5
    AST_LT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!lt_set && !lt_clr) |=> $stable(lt_irq_n)); // R9
    AST_RT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!rt_set && !rt_clr) |=> $stable(rt_irq_n)); // R9

endmodule

bind mbox_doorbell mbox_doorbell_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mbox_doorbell_bench.sv
module mbox_doorbell_bench;

    localparam int AW = 14;
    localparam logic [AW-1:0] LBOX  = 14'h3FFE;
    localparam logic [AW-1:0] RBOX  = 14'h3FFF;
    localparam logic [AW-1:0] PLAIN = 14'h3FFD;

    logic clk = 1'b0;
    logic rst_n;
    logic lt_sel_n, lt_oe_n, lt_we_n, lt_busy_n;
    logic rt_sel_n, rt_oe_n, rt_we_n, rt_busy_n;
    logic [AW-1:0] lt_addr, rt_addr;
    logic lt_irq_n, rt_irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mbox_doorbell #(.ADDR_W(AW)) u_mbox_doorbell (
        .clk(clk), .rst_n(rst_n),
        .lt_sel_n(lt_sel_n), .lt_oe_n(lt_oe_n), .lt_we_n(lt_we_n),
        .lt_addr(lt_addr), .lt_busy_n(lt_busy_n),
        .rt_sel_n(rt_sel_n), .rt_oe_n(rt_oe_n), .rt_we_n(rt_we_n),
        .rt_addr(rt_addr), .rt_busy_n(rt_busy_n),
        .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic idle();
        lt_sel_n = 1; lt_oe_n = 1; lt_we_n = 1; lt_busy_n = 1; lt_addr = '0;
        rt_sel_n = 1; rt_oe_n = 1; rt_we_n = 1; rt_busy_n = 1; rt_addr = '0;
    endtask

    // Applies current inputs across one rising edge, then samples at negedge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic lt_write(input logic [AW-1:0] a);
        lt_sel_n = 0; lt_we_n = 0; lt_addr = a;
    endtask
    task automatic rt_write(input logic [AW-1:0] a);
        rt_sel_n = 0; rt_we_n = 0; rt_addr = a;
    endtask
    task automatic lt_read(input logic [AW-1:0] a);
        lt_sel_n = 0; lt_oe_n = 0; lt_addr = a;
    endtask
    task automatic rt_read(input logic [AW-1:0] a);
        rt_sel_n = 0; rt_oe_n = 0; rt_addr = a;
    endtask

    task automatic t_reset();
        rst_n = 0; idle();
        @(negedge clk);
        chk("R1 lt during reset", lt_irq_n, 1'b1);
        chk("R1 rt during reset", rt_irq_n, 1'b1);
        rst_n = 1;
        tick();
        chk("R1 lt after reset", lt_irq_n, 1'b1);
        chk("R1 rt after reset", rt_irq_n, 1'b1);
    endtask

    task automatic t_left_doorbell();
        rt_write(LBOX); tick();
        chk("R2 lt rung", lt_irq_n, 1'b0);
        chk("R2 rt untouched", rt_irq_n, 1'b1);
        tick();
        chk("R9 lt holds", lt_irq_n, 1'b0);
        lt_read(LBOX); lt_we_n = 0; tick();   // clear with write line active
        chk("R4 lt cleared with we low", lt_irq_n, 1'b1);
        rt_write(LBOX); tick();
        lt_read(LBOX); tick();
        chk("R4 lt cleared by read", lt_irq_n, 1'b1);
    endtask

    task automatic t_right_doorbell();
        lt_write(RBOX); tick();
        chk("R3 rt rung", rt_irq_n, 1'b0);
        chk("R3 lt untouched", lt_irq_n, 1'b1);
        rt_read(RBOX); rt_we_n = 0; tick();
        chk("R5 rt cleared with we low", rt_irq_n, 1'b1);
        lt_write(RBOX); tick();
        rt_read(RBOX); tick();
        chk("R5 rt cleared by read", rt_irq_n, 1'b1);
    endtask

    task automatic t_busy_veto();
        rt_write(LBOX); rt_busy_n = 0; tick();
        chk("R6 vetoed ring lt", lt_irq_n, 1'b1);
        lt_write(RBOX); lt_busy_n = 0; tick();
        chk("R6 vetoed ring rt", rt_irq_n, 1'b1);
        rt_write(LBOX); lt_write(RBOX); tick();
        lt_read(LBOX); lt_busy_n = 0;
        rt_read(RBOX); rt_busy_n = 0; tick();
        chk("R6 vetoed ack lt", lt_irq_n, 1'b0);
        chk("R6 vetoed ack rt", rt_irq_n, 1'b0);
        lt_read(LBOX); rt_read(RBOX); tick();
        chk("R6 cleanup lt", lt_irq_n, 1'b1);
        chk("R6 cleanup rt", rt_irq_n, 1'b1);
    endtask

    task automatic t_set_wins();
        rt_write(LBOX); lt_read(LBOX); tick();
        chk("R7 lt set over clear", lt_irq_n, 1'b0);
        lt_write(RBOX); tick();
        lt_write(RBOX); rt_read(RBOX); tick();
        chk("R7 rt set over clear", rt_irq_n, 1'b0);
        rt_write(LBOX); lt_read(LBOX); lt_busy_n = 0; tick();
        chk("R7 ring with vetoed ack lt", lt_irq_n, 1'b0);
        lt_read(LBOX); rt_read(RBOX); tick();
        chk("R7 later ack lt", lt_irq_n, 1'b1);
        chk("R7 later ack rt", rt_irq_n, 1'b1);
    endtask

    task automatic t_no_side_effect();
        lt_write(LBOX); tick();
        chk("R8 own box write lt", lt_irq_n, 1'b1);
        rt_write(RBOX); tick();
        chk("R8 own box write rt", rt_irq_n, 1'b1);
        rt_write(PLAIN); lt_write(PLAIN); tick();
        chk("R8 plain write lt", lt_irq_n, 1'b1);
        chk("R8 plain write rt", rt_irq_n, 1'b1);
        rt_write(LBOX); rt_sel_n = 1; tick();
        chk("R8 deselected ring", lt_irq_n, 1'b1);
        rt_write(LBOX); tick();
        lt_sel_n = 0; lt_addr = LBOX; tick();   // no oe, no write
        chk("R8 no oe no clear", lt_irq_n, 1'b0);
        lt_read(LBOX); lt_sel_n = 1; tick();
        chk("R8 deselected ack", lt_irq_n, 1'b0);
        lt_read(PLAIN); tick();
        chk("R8 read plain", lt_irq_n, 1'b0);
        lt_read(LBOX); tick();
        chk("R4 final ack", lt_irq_n, 1'b1);
    endtask

    initial begin
        t_reset();
        t_left_doorbell();
        t_right_doorbell();
        t_busy_veto();
        t_set_wins();
        t_no_side_effect();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule